// File: doc/BRIEF.md
# Packed dot-product accumulate unit

This block is a single-stage SIMD datapath built from 32-bit lanes. For every lane it forms a short dot product of two source operands and adds the result to an accumulator lane. The byte form takes four products of an unsigned byte by a signed byte. The word form takes two products of signed 16-bit halves. Either form can wrap on overflow or clamp to the signed 32-bit range. The clamp is applied once, to the complete sum.

A write mask has one bit per lane. It selects, lane by lane, the new value or a fallback, and the `zero_mask` input decides whether that fallback is the accumulator lane or zero. The bus widths are fixed at `MAX_LANES` lanes. `LANES` sets how many lanes are active, and the inactive upper lanes always read zero. Results appear one clock after `valid_in`. A new operation can be issued every cycle.

Top module: `packed_dot_acc`

## Requirements
- R1: With `op` = 2'b00, lane j becomes acc lane j plus the four products zero-extended `src_a` byte k times sign-extended `src_b` byte k, for k = 0..3. Byte k of lane j sits at bits 32j+8k+7 : 32j+8k.
- R2: With `op` = 2'b01, lane j becomes acc lane j plus the two products of signed 16-bit halves of `src_a` and `src_b`. Half k of lane j sits at bits 32j+16k+15 : 32j+16k.
- R3: With `op` = 2'b10 (byte form), the exact sum is clamped to 0x7FFFFFFF or 0x80000000 when it leaves the signed 32-bit range.
- R4: With `op` = 2'b11 (word form), the exact sum is clamped the same way. This includes two products of (-32768)·(-32768) added to a large accumulator.
- R5: With `op[1]` = 0, a sum outside the 32-bit range keeps only its low 32 bits.
- R6: A lane whose `mask` bit is 1 takes the computed value. With `zero_mask` = 0, a lane whose bit is 0 takes its accumulator lane unchanged.
- R7: With `zero_mask` = 1, a lane whose `mask` bit is 0 outputs zero.
- R8: Lanes numbered `LANES` and above always output zero, whatever their mask bits and operands.
- R9: `valid_out` equals `valid_in` delayed by one clock, and `result` carries the operation issued in that cycle.
- R10: While `valid_in` is 0, `result` holds its last value even if the inputs change.
- R11: While `rst_n` is low, `result` and `valid_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Issue an operation this cycle |
| op | input | 2 | bit0: 1 = word form, 0 = byte form; bit1: clamp |
| zero_mask | input | 1 | Fallback for masked-off lanes: 1 = zero, 0 = accumulator |
| mask | input | MAX_LANES | Per-lane write enable |
| acc | input | 32*MAX_LANES | Accumulator lanes |
| src_a | input | 32*MAX_LANES | First source (unsigned bytes or signed halves) |
| src_b | input | 32*MAX_LANES | Second source (signed bytes or signed halves) |
| valid_out | output | 1 | Result valid |
| result | output | 32*MAX_LANES | Per-lane results |

## Verification
The hardest cases to reach are the clamping boundaries. Uniform random operands almost never push a sum past the 32-bit range, and a word-form sum near 2^31 needs both halves at -32768. The stimulus therefore plants accumulators at the two extremes and pairs them with all-0xFF by all-0x80 bytes and all-0x8000 halves, under both wrap and clamp. The random part also biases accumulators toward the range limits. A second instance with four active lanes shows that the upper lanes stay zero while set mask bits and nonzero operands are driven on them.

// File: rtl/packed_dot_acc.sv
module packed_dot_acc #(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_in,
  input  logic [1:0]               op,
  input  logic                     zero_mask,
  input  logic [MAX_LANES-1:0]     mask,
  input  logic [32*MAX_LANES-1:0]  acc,
  input  logic [32*MAX_LANES-1:0]  src_a,
  input  logic [32*MAX_LANES-1:0]  src_b,
  output logic                     valid_out,
  output logic [32*MAX_LANES-1:0]  result
);
  localparam int VW = 32 * MAX_LANES;
  localparam int SW = 36;

  function automatic logic signed [SW-1:0] byte_dot(input logic [31:0] a, input logic [31:0] b);
    logic signed [16:0] ua, sb, pr;
    logic signed [SW-1:0] tot;
    tot = '0;
    for (int k = 0; k < 4; k++) begin
      ua  = {9'd0, a[8*k +: 8]};
      sb  = {{9{b[8*k+7]}}, b[8*k +: 8]};
      pr  = ua * sb;
      tot = tot + {{(SW-17){pr[16]}}, pr};
    end
    return tot;
  endfunction

  function automatic logic signed [SW-1:0] word_dot(input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] wa, wb, pr;
    logic signed [SW-1:0] tot;
    tot = '0;
    for (int k = 0; k < 2; k++) begin
      wa  = {{16{a[16*k+15]}}, a[16*k +: 16]};
      wb  = {{16{b[16*k+15]}}, b[16*k +: 16]};
      pr  = wa * wb;
      tot = tot + {{(SW-32){pr[31]}}, pr};
    end
    return tot;
  endfunction

  logic [VW-1:0] nxt;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    if (j < LANES) begin : g_on
      logic [31:0]          s, a, b, lane_res;
      logic signed [SW-1:0] full;
      logic                 ovf;
      assign s    = acc[32*j +: 32];
      assign a    = src_a[32*j +: 32];
      assign b    = src_b[32*j +: 32];
      assign full = {{(SW-32){s[31]}}, s} + (op[0] ? word_dot(a, b) : byte_dot(a, b));
      assign ovf  = (full[SW-1:31] != '0) && (full[SW-1:31] != '1);
      assign lane_res = (op[1] && ovf) ? (full[SW-1] ? 32'h8000_0000 : 32'h7FFF_FFFF)
                                       : full[31:0];
      assign nxt[32*j +: 32] = mask[j] ? lane_res : (zero_mask ? 32'd0 : s);

      assert_merge_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !zero_mask && !mask[j]) |=> (result[32*j +: 32] == $past(acc[32*j +: 32])));
      assert_zero_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && zero_mask && !mask[j]) |=> (result[32*j +: 32] == 32'd0));
    end else begin : g_off
      assign nxt[32*j +: 32] = 32'd0;
      assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result[32*j +: 32] == 32'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= nxt;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));
endmodule

// File: tb/test_packed_dot_acc.sv
module test_packed_dot_acc;
  localparam int ML = 8;
  localparam int VW = 32 * ML;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_in = 1'b0;
  logic [1:0]    op = 2'b00;
  logic          zero_mask = 1'b0;
  logic [ML-1:0] mask = '0;
  logic [VW-1:0] acc = '0, src_a = '0, src_b = '0;
  logic          vo_w, vo_n;
  logic [VW-1:0] res_w, res_n;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  packed_dot_acc #(.MAX_LANES(ML), .LANES(8)) i_packed_dot_acc (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .zero_mask(zero_mask),
    .mask(mask), .acc(acc), .src_a(src_a), .src_b(src_b),
    .valid_out(vo_w), .result(res_w));

  packed_dot_acc #(.MAX_LANES(ML), .LANES(4)) i_packed_dot_acc_lo (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .zero_mask(zero_mask),
    .mask(mask), .acc(acc), .src_a(src_a), .src_b(src_b),
    .valid_out(vo_n), .result(res_n));

  function automatic logic [VW-1:0] model(input logic [1:0] o, input logic zm,
      input logic [ML-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input int lanes);
    logic [VW-1:0] r;
    longint sum;
    logic signed [7:0]  sb;
    logic signed [15:0] ha, hb;
    r = '0;
    for (int j = 0; j < lanes; j++) begin
      sum = longint'($signed(s[32*j +: 32]));
      if (o[0]) begin
        for (int k = 0; k < 2; k++) begin
          ha = a[32*j+16*k +: 16];
          hb = b[32*j+16*k +: 16];
          sum = sum + longint'(ha) * longint'(hb);
        end
      end else begin
        for (int k = 0; k < 4; k++) begin
          sb = b[32*j+8*k +: 8];
          sum = sum + longint'(a[32*j+8*k +: 8]) * longint'(sb);
        end
      end
      if (o[1] && sum > 64'sd2147483647)  sum = 64'sd2147483647;
      if (o[1] && sum < -64'sd2147483648) sum = -64'sd2147483648;
      if (m[j]) r[32*j +: 32] = sum[31:0];
      else      r[32*j +: 32] = zm ? 32'd0 : s[32*j +: 32];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic issue(input string tag, input logic [1:0] o, input logic zm,
      input logic [ML-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] a,
      input logic [VW-1:0] b);
    logic [VW-1:0] ew, en;
    ew = model(o, zm, m, s, a, b, 8);
    en = model(o, zm, m, s, a, b, 4);
    op = o; zero_mask = zm; mask = m; acc = s; src_a = a; src_b = b; valid_in = 1'b1;
    @(posedge clk); @(negedge clk);
    valid_in = 1'b0;
    chk({tag, " R9 valid"}, {255'd0, vo_w}, {255'd0, 1'b1});
    chk(tag, res_w, ew);
    chk({tag, " R8 narrow"}, res_n, en);
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < ML; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] rep(input logic [31:0] w);
    logic [VW-1:0] v;
    for (int i = 0; i < ML; i++) v[32*i +: 32] = w;
    return v;
  endfunction

  initial begin
    logic [VW-1:0] s, a, b, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset result", res_w, '0);
    chk("R11 reset valid", {255'd0, vo_w}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // byte extremes: 255 * -128 per byte, against both accumulator limits
    issue("R1", 2'b00, 1'b0, '1, '0, rep(32'hFFFF_FFFF), rep(32'h8080_8080));
    issue("R5 byte wrap", 2'b00, 1'b0, '1, rep(32'h8000_0000), rep(32'hFFFF_FFFF), rep(32'h8080_8080));
    issue("R3 clamp low", 2'b10, 1'b0, '1, rep(32'h8000_0000), rep(32'hFFFF_FFFF), rep(32'h8080_8080));
    issue("R3 clamp high", 2'b10, 1'b0, '1, rep(32'h7FFF_FF00), rep(32'hFFFF_FFFF), rep(32'h7F7F_7F7F));
    // word extremes: (-32768)^2 twice
    issue("R2", 2'b01, 1'b0, '1, '0, rep(32'h8000_8000), rep(32'h8000_8000));
    issue("R5 word wrap", 2'b01, 1'b0, '1, rep(32'h7FFF_FFFF), rep(32'h8000_8000), rep(32'h8000_8000));
    issue("R4 clamp high", 2'b11, 1'b0, '1, rep(32'h7FFF_FFFF), rep(32'h8000_8000), rep(32'h8000_8000));
    issue("R4 clamp low", 2'b11, 1'b0, '1, rep(32'h8000_0000), rep(32'h8000_8000), rep(32'h7FFF_7FFF));
    issue("R4 in range", 2'b11, 1'b0, '1, rep(32'h0000_1234), rep(32'h0003_FFFE), rep(32'hFFFF_0005));
    // masks
    s = rnd_vec(); a = rnd_vec(); b = rnd_vec();
    issue("R6 mask zero merge", 2'b01, 1'b0, '0, s, a, b);
    issue("R7 mask zero zeroing", 2'b00, 1'b1, '0, s, a, b);
    issue("R6 mask ones", 2'b10, 1'b1, '1, s, a, b);
    issue("R7 mixed", 2'b11, 1'b1, 8'hA5, s, a, b);
    issue("R6 mixed", 2'b00, 1'b0, 8'h5A, s, a, b);

    // R10: change inputs with valid low and expect no change
    held = res_w;
    op = 2'b01; mask = '1; zero_mask = 1'b1; acc = rnd_vec(); src_a = rnd_vec(); src_b = rnd_vec();
    @(posedge clk); @(negedge clk);
    chk("R10 hold", res_w, held);
    chk("R9 idle", {255'd0, vo_w}, '0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      s = rnd_vec(); a = rnd_vec(); b = rnd_vec();
      if (n % 3 == 0)
        for (int i = 0; i < ML; i++)
          s[32*i +: 32] = ($urandom & 1) ? 32'h7FFF_FFFF - 32'($urandom_range(0, 70000))
                                         : 32'h8000_0000 + 32'($urandom_range(0, 70000));
      issue(op_tag(o), o, 1'($urandom), 8'($urandom), s, a, b);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule